// File: doc/BRIEF.md
# Banked Interrupt Controller Register File

This block collects 72 level-sensitive interrupt sources into three groups: a small group of 8 core sources and two wide peripheral groups of 32 sources each. Flat source numbers run 0–7 for the core group, 8–39 for the first peripheral group and 40–71 for the second. Each source has an enable bit. Software never writes the enable state directly. It sets bits through one register of a pair and clears them through the other. A source is pending when its input is high and its enable bit is set. Any pending source raises the single processor interrupt line.

Software reads the pending state through a 32-bit register port. Each peripheral group has a full 32-bit pending view. A summary word lets a handler find most sources with one read. It carries the core pending bits, eleven frequently used peripheral sources copied as direct bits, and one flag per peripheral group. A flag is set only when that group has a pending source that is not among the copied bits. A 32-bit control word for fast-interrupt routing is kept as plain storage.

Top module: `banked_irq_regs`

## Requirements
- R1: While reset is asserted, every enable bit and the fast-interrupt control word are zero, and `irq_o` is low.
- R2: A write to a set register (first group 0x10, second group 0x14, core 0x18) sets each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value. The new state is visible from the clock edge that accepts the write. Cycles without a write leave the enables unchanged.
- R3: A write to a clear register (first group 0x1C, second group 0x20, core 0x24) clears each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R4: Reading either register of a group's set/clear pair returns that group's current enable mask. Data bit n maps to source n of the group. For the core group, bits 31:8 read as zero.
- R5: Offset 0x04 reads the first group's inputs ANDed with its enables, and offset 0x08 does the same for the second group. Writes to these offsets and to 0x00 change no state.
- R6: Summary word (offset 0x00) bits 7:0 are the pending core sources.
- R7: Summary bits 10 to 14 copy the pending state of first-group sources 7, 9, 10, 18 and 19, in that order. Bits 15 to 20 copy second-group sources 21, 22, 23, 24, 25 and 30, in that order.
- R8: Summary bit 8 is set when any first-group source outside its copied set is pending. Bit 9 does the same for the second group.
- R9: Summary bits 31:21 always read zero. Unmapped offsets read zero.
- R10: `irq_o` is high in exactly those cycles in which at least one enabled source has its input high.
- R11: The fast-interrupt control word at offset 0x0C stores all 32 bits written to it and reads them back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 72 | Level interrupt inputs, flat numbering |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Processor interrupt request |

## Verification
Directed patterns check single sources one at a time. One case is a copied first-group source, which must raise only its copied bit and not the group flag. Another is a non-copied neighbour, which must raise only the flag. The last is the highest copied second-group source. Set and clear writes with overlapping data patterns tell a true read-modify update apart from a plain overwrite. Inputs driven high at disabled positions show whether masking is applied. A long run of random inputs, with random set, clear and control writes mixed with writes to the read-only offsets, is compared on every clock against a behavioural model. That run covers combinations where copied and non-copied sources are pending together.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W  = 32;
  localparam int CORE_N  = 8;
  localparam int GRP_N   = 32;
  localparam int SRC_N   = CORE_N + 2 * GRP_N;
  localparam int G1_BASE = CORE_N;
  localparam int G2_BASE = CORE_N + GRP_N;

  // register offsets (software-visible, fixed)
  localparam int OFF_SUM    = 'h00;
  localparam int OFF_PND1   = 'h04;
  localparam int OFF_PND2   = 'h08;
  localparam int OFF_FIQ    = 'h0C;
  localparam int OFF_SET1   = 'h10;
  localparam int OFF_SET2   = 'h14;
  localparam int OFF_SET0   = 'h18;
  localparam int OFF_CLR1   = 'h1C;
  localparam int OFF_CLR2   = 'h20;
  localparam int OFF_CLR0   = 'h24;

  // summary word layout
  localparam int SUM_FLAG1 = 8;
  localparam int SUM_FLAG2 = 9;
  localparam int CP1_N     = 5;
  localparam int CP2_N     = 6;
  localparam int CP1_POS   = 10;
  localparam int CP2_POS   = CP1_POS + CP1_N;
  localparam int SUM_USED  = CP2_POS + CP2_N;
  localparam int CP1_IDX [CP1_N] = '{7, 9, 10, 18, 19};
  localparam int CP2_IDX [CP2_N] = '{21, 22, 23, 24, 25, 30};

  function automatic logic [GRP_N-1:0] cp1_mask();
    logic [GRP_N-1:0] m = '0;
    for (int k = 0; k < CP1_N; k++) m[CP1_IDX[k]] = 1'b1;
    return m;
  endfunction

  function automatic logic [GRP_N-1:0] cp2_mask();
    logic [GRP_N-1:0] m = '0;
    for (int k = 0; k < CP2_N; k++) m[CP2_IDX[k]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irqc_en_bank.sv
module irqc_en_bank #(
  parameter int          W      = 32,
  parameter int          AW     = 6,
  parameter int unsigned SET_A  = 0,
  parameter int unsigned CLR_A  = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  en_o
);
  logic [W-1:0] en_q;
  logic         hit_set, hit_clr;

  assign hit_set = wr_en_i && (addr_i == AW'(SET_A));
  assign hit_clr = wr_en_i && (addr_i == AW'(CLR_A));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (hit_set) en_q <= en_q | wdata_i;
    else if (hit_clr) en_q <= en_q & ~wdata_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/irqc_summary.sv
module irqc_summary
  import irqc_pkg::*;
(
  input  logic [CORE_N-1:0] pnd0_i,
  input  logic [GRP_N-1:0]  pnd1_i,
  input  logic [GRP_N-1:0]  pnd2_i,
  output logic [DATA_W-1:0] sum_o
);
  localparam logic [GRP_N-1:0] M1 = cp1_mask();
  localparam logic [GRP_N-1:0] M2 = cp2_mask();

  logic [CP1_N-1:0] cp1;
  logic [CP2_N-1:0] cp2;

  for (genvar k = 0; k < CP1_N; k++) begin : g_cp1
    assign cp1[k] = pnd1_i[CP1_IDX[k]];
  end
  for (genvar k = 0; k < CP2_N; k++) begin : g_cp2
    assign cp2[k] = pnd2_i[CP2_IDX[k]];
  end

  always_comb begin
    sum_o = '0;
    sum_o[CORE_N-1:0]             = pnd0_i;
    sum_o[SUM_FLAG1]              = |(pnd1_i & ~M1);
    sum_o[SUM_FLAG2]              = |(pnd2_i & ~M2);
    sum_o[CP1_POS +: CP1_N]       = cp1;
    sum_o[CP2_POS +: CP2_N]       = cp2;
  end
endmodule

// File: rtl/banked_irq_regs.sv
module banked_irq_regs
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [71:0]       src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  logic [CORE_N-1:0] en_core, pnd0;
  logic [GRP_N-1:0]  en_grp1, en_grp2, pnd1, pnd2;
  logic [DATA_W-1:0] sum_w, fiq_q;

  irqc_en_bank #(.W(CORE_N), .AW(ADDR_W), .SET_A(OFF_SET0), .CLR_A(OFF_CLR0)) u_en0 (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i(wdata_i[CORE_N-1:0]), .en_o(en_core));
  irqc_en_bank #(.W(GRP_N), .AW(ADDR_W), .SET_A(OFF_SET1), .CLR_A(OFF_CLR1)) u_en1 (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i(wdata_i[GRP_N-1:0]), .en_o(en_grp1));
  irqc_en_bank #(.W(GRP_N), .AW(ADDR_W), .SET_A(OFF_SET2), .CLR_A(OFF_CLR2)) u_en2 (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i(wdata_i[GRP_N-1:0]), .en_o(en_grp2));

  assign pnd0 = src_i[CORE_N-1:0]       & en_core;
  assign pnd1 = src_i[G1_BASE +: GRP_N] & en_grp1;
  assign pnd2 = src_i[G2_BASE +: GRP_N] & en_grp2;

  irqc_summary u_sum (.pnd0_i(pnd0), .pnd1_i(pnd1), .pnd2_i(pnd2), .sum_o(sum_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   fiq_q <= '0;
    else if (wr_en_i && addr_i == ADDR_W'(OFF_FIQ)) fiq_q <= wdata_i;
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(OFF_SUM):                    rdata_o = sum_w;
      ADDR_W'(OFF_PND1):                   rdata_o = pnd1;
      ADDR_W'(OFF_PND2):                   rdata_o = pnd2;
      ADDR_W'(OFF_FIQ):                    rdata_o = fiq_q;
      ADDR_W'(OFF_SET1), ADDR_W'(OFF_CLR1): rdata_o = en_grp1;
      ADDR_W'(OFF_SET2), ADDR_W'(OFF_CLR2): rdata_o = en_grp2;
      ADDR_W'(OFF_SET0), ADDR_W'(OFF_CLR0): rdata_o = DATA_W'(en_core);
      default:                             rdata_o = '0;
    endcase
  end

  assign irq_o = |{pnd2, pnd1, pnd0};
endmodule

// File: rtl/banked_irq_regs_chk.sv
module banked_irq_regs_chk
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              irq_o,
  input logic [CORE_N-1:0] en_core,
  input logic [GRP_N-1:0]  en_grp1,
  input logic [GRP_N-1:0]  en_grp2,
  input logic [DATA_W-1:0] sum_w,
  input logic [DATA_W-1:0] fiq_q
);
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (en_core == '0 && en_grp1 == '0 && en_grp2 == '0 && fiq_q == '0 && !irq_o));

  assert_set_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFF_SET1)) |=> ((en_grp1 & $past(wdata_i)) == $past(wdata_i)));

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(en_grp1) && $stable(en_grp2) && $stable(en_core)));

  assert_clear_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFF_CLR2)) |=> ((en_grp2 & $past(wdata_i)) == '0));

  assert_upper_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_w[DATA_W-1:SUM_USED] == '0);

  assert_irq_vs_summary_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (sum_w != '0));

  assert_fiq_store_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFF_FIQ)) |=> (fiq_q == $past(wdata_i)));
endmodule

bind banked_irq_regs banked_irq_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .irq_o,
  .en_core, .en_grp1, .en_grp2, .sum_w, .fiq_q);

// File: tb/banked_irq_regs_tb_top.sv
module banked_irq_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [71:0] src_i = '0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_cmp = 0, n_bad = 0;
  bit live = 0, done = 0;

  logic [71:0] en_m = '0;
  logic [31:0] fiq_m = '0;
  int cp1 [5] = '{7, 9, 10, 18, 19};
  int cp2 [6] = '{21, 22, 23, 24, 25, 30};

  always #2 clk_i = ~clk_i;

  banked_irq_regs dut_i (.clk_i, .rst_ni, .src_i, .wr_en_i, .addr_i, .wdata_i, .rdata_o, .irq_o);

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h t=%0t", req, addr_i, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_sum();
    logic [31:0] s = '0;
    logic [71:0] p = src_i & en_m;
    s[7:0] = p[7:0];
    for (int i = 0; i < 32; i++) begin
      int hit = -1;
      for (int k = 0; k < 5; k++) if (cp1[k] == i) hit = k;
      if (p[8+i]) begin
        if (hit >= 0) s[10+hit] = 1'b1; else s[8] = 1'b1;
      end
      hit = -1;
      for (int k = 0; k < 6; k++) if (cp2[k] == i) hit = k;
      if (p[40+i]) begin
        if (hit >= 0) s[15+hit] = 1'b1; else s[9] = 1'b1;
      end
    end
    return s;
  endfunction

  function automatic logic [31:0] exp_rd(logic [5:0] a);
    case (a)
      6'h00: return exp_sum();
      6'h04: return src_i[39:8] & en_m[39:8];
      6'h08: return src_i[71:40] & en_m[71:40];
      6'h0C: return fiq_m;
      6'h10, 6'h1C: return en_m[39:8];
      6'h14, 6'h20: return en_m[71:40];
      6'h18, 6'h24: return {24'h0, en_m[7:0]};
      default: return 32'h0;
    endcase
  endfunction

  // per-clock compare of the interrupt line (R10)
  always @(negedge clk_i) if (live) chk(irq_o == |(src_i & en_m), "R10", 32'(irq_o), 32'(|(src_i & en_m)));

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(posedge clk_i); #1;
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    case (a)
      6'h10: en_m[39:8]  = en_m[39:8]  | d;
      6'h14: en_m[71:40] = en_m[71:40] | d;
      6'h18: en_m[7:0]   = en_m[7:0]   | d[7:0];
      6'h1C: en_m[39:8]  = en_m[39:8]  & ~d;
      6'h20: en_m[71:40] = en_m[71:40] & ~d;
      6'h24: en_m[7:0]   = en_m[7:0]   & ~d[7:0];
      6'h0C: fiq_m = d;
      default: ;
    endcase
    #1 wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, string req);
    @(posedge clk_i); #1 addr_i = a;
    @(negedge clk_i);
    chk(rdata_o === exp_rd(a), req, rdata_o, exp_rd(a));
  endtask

  task automatic rd_const(logic [5:0] a, logic [31:0] e, string req);
    @(posedge clk_i); #1 addr_i = a;
    @(negedge clk_i);
    chk(rdata_o === e, req, rdata_o, e);
  endtask

  task automatic set_src(logic [71:0] s);
    @(posedge clk_i); #1 src_i = s;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [5:0] addrs [11] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h1C, 6'h20, 6'h24, 6'h28};
    logic [5:0] wrs [10]   = '{6'h10, 6'h14, 6'h18, 6'h1C, 6'h20, 6'h24, 6'h0C, 6'h00, 6'h04, 6'h08};
    #1 rst_ni = 1'b0;
    src_i = '1;
    repeat (3) @(posedge clk_i);
    // R1: reset state
    @(negedge clk_i);
    chk(irq_o == 1'b0, "R1", 32'(irq_o), 0);
    #1 rst_ni = 1'b1;
    live = 1;
    foreach (addrs[i]) if (addrs[i] != 6'h00 && addrs[i] != 6'h04 && addrs[i] != 6'h08)
      rd_const(addrs[i], 32'h0, "R1");

    // R2/R4: set with overlap, read back at set and clear offsets
    set_src('0);
    wr(6'h10, 32'h0000_F0F0);
    wr(6'h10, 32'h0000_0FF0);
    rd_const(6'h10, 32'h0000_FFF0, "R2");
    rd_const(6'h1C, 32'h0000_FFF0, "R4");
    // R3: clear only the given bits
    wr(6'h1C, 32'h0000_0330);
    rd_const(6'h10, 32'h0000_FCC0, "R3");
    wr(6'h18, 32'hFFFF_FF81);
    rd_const(6'h24, 32'h0000_0081, "R4");
    wr(6'h24, 32'h0000_0001);
    rd_const(6'h18, 32'h0000_0080, "R3");
    // R10: disabled sources do not raise the line
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h24, 32'hFF);
    set_src({32'h0, 32'hFFFF_FFFF, 8'hFF});
    rd_const(6'h00, 32'h0, "R10");
    // R5: writes to read-only offsets change nothing
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h14, 32'hFFFF_FFFF);
    wr(6'h04, 32'h0);
    wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h00, 32'hFFFF_FFFF);
    rd_const(6'h04, 32'hFFFF_FFFF, "R5");
    rd_const(6'h10, 32'hFFFF_FFFF, "R5");
    rd_const(6'h14, 32'hFFFF_FFFF, "R5");
    // R7/R8: copied source vs neighbour
    set_src(72'h1 << (8 + 7));
    rd_const(6'h00, 32'h0000_0400, "R7");
    set_src(72'h1 << (8 + 8));
    rd_const(6'h00, 32'h0000_0100, "R8");
    set_src(72'h1 << (40 + 30));
    rd_const(6'h00, 32'h0010_0000, "R7");
    set_src(72'h1 << (40 + 31));
    rd_const(6'h00, 32'h0000_0200, "R8");
    // R6: core bits
    wr(6'h18, 32'h0000_00A5);
    set_src({64'h0, 8'hFF});
    rd_const(6'h00, 32'h0000_00A5, "R6");
    // R11: control word
    wr(6'h0C, 32'hDEAD_BEEF);
    rd_const(6'h0C, 32'hDEAD_BEEF, "R11");
    // R9: everything pending, upper bits and unmapped offset zero
    wr(6'h18, 32'hFF);
    set_src('1);
    rd_const(6'h00, 32'h001F_FFFF, "R9");
    rd_const(6'h2C, 32'h0, "R9");

    // random mix vs model (R2..R11)
    for (int it = 0; it < 300; it++) begin
      set_src({8'($urandom), $urandom & $urandom, $urandom & $urandom, 8'($urandom)});
      wr(wrs[$urandom_range(0, 9)], $urandom);
      foreach (addrs[i]) rd(addrs[i], "R5-R9 random");
    end
    finish_run();
  end
endmodule